// File: doc/BRIEF.md
# Cycle-Steal DMA Request Controller

This block turns a pulsed request from an external peripheral into single-operand DMA transfers. The request line is active low. The block samples it on every clock and looks for a high-to-low transition. A detected transition sets one pending flag. The flag stays set until the controller starts to serve it, and any transitions that arrive while it is set are dropped. Serving a request moves exactly one operand: a read bus cycle, then a write bus cycle. The acknowledge strobe goes to the peripheral only during the cycle that touches it.

A configuration bit places the peripheral on one side of the transfer. Set to 1, the peripheral is read and the memory-side pointer is the destination. Set to 0, the peripheral is written and the memory-side pointer is the source. A second bit chooses between synchronous sampling and sampling through one extra synchronizer clock.

The bus interface is a request/grant pair plus a cycle-done input. The controller loads an operand count and two pointers when it is armed. When the count runs out it reports done and ignores requests until it is armed again.

The state machine has six states:
- `ST_IDLE`: armed, waiting for a pending request.
- `ST_RD_REQ`: bus requested for the read.
- `ST_RD_CYC`: read cycle in progress.
- `ST_WR_REQ`: grant was lost after the read; waiting for it to return.
- `ST_WR_CYC`: write cycle in progress.
- `ST_FIN`: count exhausted, or not yet armed.

Transitions:
- Reset goes to `ST_FIN`.
- An accepted arm moves `ST_FIN` to `ST_IDLE`.
- `ST_IDLE` moves to `ST_RD_REQ` when a request is pending.
- `ST_RD_REQ` moves to `ST_RD_CYC` on grant. This is the service start.
- `ST_RD_CYC` ends on cycle done. It moves to `ST_WR_CYC` if the grant is still held, otherwise to `ST_WR_REQ`.
- `ST_WR_REQ` moves to `ST_WR_CYC` on grant.
- `ST_WR_CYC` ends on cycle done and moves to one of:
  - `ST_FIN` when the last operand has been written.
  - `ST_RD_CYC`, back to back, when a request is pending and the grant is held. This is also a service start.
  - `ST_RD_REQ` when a request is pending but the grant is not held.
  - `ST_IDLE` otherwise.

Top module: `csdma_top`

## Requirements
- R1: After reset `done`=1 and `bus_req`, `cyc_active` and `per_ack` are 0. A pulse on `arm` with nonzero `arm_count` in the idle or done state loads the count and both pointers, and clears `done`. An `arm` pulse with `arm_count`=0 leaves `done` at 1.
- R2: With `cfg_sync_req`=1, a high-to-low change of `per_req_n` first sampled at rising edge k gives `bus_req`=1 after edge k+2 (from the idle state). With `cfg_sync_req`=0 this happens one clock later, after edge k+3.
- R3: A single pending flag holds one request. Further falling edges while it is set and service has not started are discarded, so they produce no additional transfer.
- R4: The pending flag clears on the clock in which service starts. A falling edge detected in that same clock sets the flag again and yields one more transfer.
- R5: Each served request produces exactly one read cycle (`cyc_active`=1, `cyc_write`=0, `bus_addr`=source pointer), then one write cycle (`cyc_write`=1, `bus_addr`=destination pointer). During the write, `wr_data` equals the `rd_data` captured when the read ended.
- R6: `per_ack` is 1 only while `cyc_active`=1. With `cfg_periph_src`=1 it accompanies the read cycle; with `cfg_periph_src`=0 it accompanies the write cycle.
- R7: If `bus_grant`=0 when the read ends, no cycle runs and `bus_req` stays 1 until the grant returns. The write then carries the held read data.
- R8: If a request is pending when a write ends and `bus_grant`=1, the next read cycle starts on the very next clock.
- R9: After each write, the memory-side pointer advances by 1: the destination when `cfg_periph_src`=1, the source when 0. The peripheral-side pointer stays fixed.
- R10: The operand count decrements on each completed write. When it reaches zero, `done`=1 and `bus_req`=0, and falling edges on `per_req_n` start no transfer until the next accepted arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| per_req_n | input | 1 | Peripheral request, falling edge = one operand |
| per_ack | output | 1 | Acknowledge strobe to the peripheral |
| cfg_periph_src | input | 1 | 1: peripheral is read; 0: peripheral is written |
| cfg_sync_req | input | 1 | 1: synchronous sampling; 0: one extra synchronizer clock |
| arm | input | 1 | Load count and pointers, clear done |
| arm_count | input | CW | Operands to move |
| arm_src | input | AW | Source pointer start |
| arm_dst | input | AW | Destination pointer start |
| bus_req | output | 1 | Bus mastership request |
| bus_grant | input | 1 | Bus mastership grant |
| cyc_active | output | 1 | Bus cycle in progress (address strobe) |
| cyc_write | output | 1 | 1: current cycle is a write |
| cyc_done | input | 1 | Current bus cycle completes this clock |
| bus_addr | output | AW | Cycle address |
| rd_data | input | DW | Read data, taken at read completion |
| wr_data | output | DW | Write data (held read operand) |
| done | output | 1 | Count exhausted or not armed |

## Verification
A wrong pending flag shows up as a wrong number of write cycles within a few clocks of the grant being released. Extra transfers mean lost discards; a missing transfer means a lost same-clock edge. An error in the state register or the direction decode moves `per_ack` onto the wrong cycle, or makes it appear with no cycle, and the scoreboard catches this on the very first transfer. An error in the pointers or the hold register shows as a wrong address or data on the next write. A broken grant-loss path shows as a cycle strobe while the grant is low, or as stale write data.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_CYC,
        ST_WR_REQ,
        ST_WR_CYC,
        ST_FIN
    } xfer_state_t;
endpackage

// File: rtl/csdma_req_edge.sv
module csdma_req_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic sync_mode,
    input  logic enable,
    input  logic svc_start,
    input  logic flush,
    output logic pending
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   sel_q;
    logic                   prev_q;
    logic                   fall;

    // sampling chain; stage 0 is the synchronous sample, the last adds delay
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= req_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sel_q = sync_mode ? chain[0] : chain[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sel_q;
    end

    assign fall = prev_q & ~sel_q;

    // single pending latch; an edge in the service-start clock re-sets it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pending <= 1'b0;
        else if (flush) pending <= 1'b0;
        else            pending <= (fall & enable) | (pending & ~svc_start);
    end
endmodule

// File: rtl/csdma_counter.sv
module csdma_counter #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cnt_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic          periph_src,
    input  logic          step,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic          last
);
    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            src_ptr <= '0;
            dst_ptr <= '0;
        end else if (load) begin
            cnt     <= cnt_in;
            src_ptr <= src_in;
            dst_ptr <= dst_in;
        end else if (step) begin
            cnt <= cnt - ONE_C;
            if (periph_src) dst_ptr <= dst_ptr + ONE_A;
            else            src_ptr <= src_ptr + ONE_A;
        end
    end

    assign last = (cnt == ONE_C);
endmodule

// File: rtl/csdma_fsm.sv
module csdma_fsm
    import csdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pending,
    input  logic        bus_grant,
    input  logic        cyc_done,
    input  logic        last,
    input  logic        arm_ok,
    input  logic        periph_src,
    output xfer_state_t state,
    output logic        svc_start,
    output logic        rd_done,
    output logic        wr_done,
    output logic        bus_req,
    output logic        cyc_active,
    output logic        cyc_write,
    output logic        per_ack,
    output logic        done
);
    xfer_state_t nxt;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!arm_ok && pending) nxt = ST_RD_REQ;
            ST_RD_REQ: if (bus_grant) nxt = ST_RD_CYC;
            ST_RD_CYC: if (cyc_done) nxt = bus_grant ? ST_WR_CYC : ST_WR_REQ;
            ST_WR_REQ: if (bus_grant) nxt = ST_WR_CYC;
            ST_WR_CYC: begin
                if (cyc_done) begin
                    if (last)                      nxt = ST_FIN;
                    else if (pending && bus_grant) nxt = ST_RD_CYC;
                    else if (pending)              nxt = ST_RD_REQ;
                    else                           nxt = ST_IDLE;
                end
            end
            ST_FIN:    if (arm_ok) nxt = ST_IDLE;
            default:   nxt = ST_FIN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FIN;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        bus_req    = 1'b0;
        cyc_active = 1'b0;
        cyc_write  = 1'b0;
        per_ack    = 1'b0;
        done       = 1'b0;
        rd_done    = 1'b0;
        wr_done    = 1'b0;
        svc_start  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RD_REQ: begin
                bus_req   = 1'b1;
                svc_start = bus_grant;
            end
            ST_RD_CYC: begin
                bus_req    = 1'b1;
                cyc_active = 1'b1;
                per_ack    = periph_src;
                rd_done    = cyc_done;
            end
            ST_WR_REQ: bus_req = 1'b1;
            ST_WR_CYC: begin
                bus_req    = 1'b1;
                cyc_active = 1'b1;
                cyc_write  = 1'b1;
                per_ack    = ~periph_src;
                wr_done    = cyc_done;
                svc_start  = cyc_done & ~last & pending & bus_grant;
            end
            ST_FIN:  done = 1'b1;
            default: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/csdma_top.sv
module csdma_top
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          per_req_n,
    output logic          per_ack,
    input  logic          cfg_periph_src,
    input  logic          cfg_sync_req,
    input  logic          arm,
    input  logic [CW-1:0] arm_count,
    input  logic [AW-1:0] arm_src,
    input  logic [AW-1:0] arm_dst,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          cyc_active,
    output logic          cyc_write,
    input  logic          cyc_done,
    output logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] wr_data,
    output logic          done
);
    xfer_state_t   state;
    logic          pending, svc_start, rd_done, wr_done, last, arm_ok;
    logic [AW-1:0] src_ptr, dst_ptr;

    assign arm_ok = arm && (arm_count != '0) &&
                    ((state == ST_IDLE) || (state == ST_FIN));

    csdma_req_edge #(.SYNC_STAGES(2)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (per_req_n),
        .sync_mode (cfg_sync_req),
        .enable    (state != ST_FIN),
        .svc_start (svc_start),
        .flush     (arm_ok),
        .pending   (pending)
    );

    csdma_counter #(.AW(AW), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (arm_ok),
        .cnt_in     (arm_count),
        .src_in     (arm_src),
        .dst_in     (arm_dst),
        .periph_src (cfg_periph_src),
        .step       (wr_done),
        .src_ptr    (src_ptr),
        .dst_ptr    (dst_ptr),
        .last       (last)
    );

    csdma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .bus_grant  (bus_grant),
        .cyc_done   (cyc_done),
        .last       (last),
        .arm_ok     (arm_ok),
        .periph_src (cfg_periph_src),
        .state      (state),
        .svc_start  (svc_start),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .bus_req    (bus_req),
        .cyc_active (cyc_active),
        .cyc_write  (cyc_write),
        .per_ack    (per_ack),
        .done       (done)
    );

    // operand hold register: survives a lost grant between read and write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wr_data <= '0;
        else if (rd_done) wr_data <= rd_data;
    end

    assign bus_addr = cyc_write ? dst_ptr : src_ptr;
endmodule

// File: rtl/csdma_chk.sv
module csdma_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          per_ack,
    input logic          cfg_periph_src,
    input logic          bus_req,
    input logic          cyc_active,
    input logic          cyc_write,
    input logic          cyc_done,
    input logic          done,
    input logic          pending,
    input logic          svc_start,
    input logic [DW-1:0] wr_data
);
    a_r6_ack_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> cyc_active);

    a_r6_ack_side: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (cyc_write != cfg_periph_src));

    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && !cyc_write && cyc_done) |=> !(cyc_active && !cyc_write));

    a_r3_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !svc_start) |=> pending);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    a_r7_hold_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data) |-> $past(cyc_active && !cyc_write && cyc_done));
endmodule

bind csdma_top csdma_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .per_ack        (per_ack),
    .cfg_periph_src (cfg_periph_src),
    .bus_req        (bus_req),
    .cyc_active     (cyc_active),
    .cyc_write      (cyc_write),
    .cyc_done       (cyc_done),
    .done           (done),
    .pending        (pending),
    .svc_start      (svc_start),
    .wr_data        (wr_data)
);

// File: tb/sim_csdma_top.sv
`timescale 1ns/1ps
module sim_csdma_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, per_req_n = 1'b1, per_ack;
    logic          cfg_periph_src = 1'b1, cfg_sync_req = 1'b1;
    logic          arm = 1'b0;
    logic [CW-1:0] arm_count = '0;
    logic [AW-1:0] arm_src = '0, arm_dst = '0, bus_addr;
    logic          bus_req, bus_grant, cyc_active, cyc_write, cyc_done, done;
    logic [DW-1:0] rd_data, wr_data;
    logic          grant_en = 1'b1;

    assign bus_grant = grant_en;
    assign cyc_done  = cyc_active;
    assign rd_data   = bus_addr ^ 16'hA5C3;

    csdma_top #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

    typedef struct {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [DW-1:0] data;
        logic          ack_rd;
    } item_t;
    item_t sbq[$];

    int checks = 0, fails = 0, wr_count = 0, nidx = 0, prev_wr_idx = 0, last_gap = 0;
    logic [AW-1:0] m_src, m_dst;
    logic          m_psrc;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: compute the next expected transfer and push it
    task automatic push_xfer();
        item_t it;
        it.rd     = m_src;
        it.wr     = m_dst;
        it.data   = m_src ^ 16'hA5C3;
        it.ack_rd = m_psrc;
        if (m_psrc) m_dst = m_dst + 1'b1;
        else        m_src = m_src + 1'b1;
        sbq.push_back(it);
    endtask

    task automatic do_arm(input int cnt, input logic [AW-1:0] s, input logic [AW-1:0] d, input logic ps);
        @(negedge clk);
        arm = 1'b1; arm_count = CW'(cnt); arm_src = s; arm_dst = d; cfg_periph_src = ps;
        @(negedge clk);
        arm = 1'b0;
        if (cnt != 0) begin m_src = s; m_dst = d; m_psrc = ps; end
    endtask

    task automatic pulse();
        @(negedge clk) per_req_n = 1'b0;
        @(negedge clk) per_req_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain();
        int k = 0;
        while ((sbq.size() != 0 || bus_req) && k < 200) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic latency(output int n);
        n = 0;
        @(negedge clk) per_req_n = 1'b0;
        while (n < 10) begin
            @(negedge clk);
            n++;
            if (n == 1) per_req_n = 1'b1;
            if (bus_req) break;
        end
    endtask

    // monitor: compare completed cycles with the scoreboard
    always @(negedge clk) begin
        nidx++;
        if (rst_n && cyc_active && cyc_done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R5 unexpected cycle", {63'd0, cyc_write}, 0);
            end else if (!cyc_write) begin
                check(bus_addr == sbq[0].rd, "R5/R9 read address", bus_addr, sbq[0].rd);
                check(per_ack == sbq[0].ack_rd, "R6 ack on read", per_ack, sbq[0].ack_rd);
                last_gap = nidx - prev_wr_idx;
            end else begin
                check(bus_addr == sbq[0].wr, "R5/R9 write address", bus_addr, sbq[0].wr);
                check(wr_data == sbq[0].data, "R5/R7 write data", wr_data, sbq[0].data);
                check(per_ack == !sbq[0].ack_rd, "R6 ack on write", per_ack, !sbq[0].ack_rd);
                void'(sbq.pop_front());
                wr_count++;
                prev_wr_idx = nidx;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, base;
        bit seen;
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R1 reset done", done, 1);
        check(bus_req == 1'b0, "R1 reset bus_req", bus_req, 0);
        check(cyc_active == 1'b0, "R1 reset cyc_active", cyc_active, 0);
        check(per_ack == 1'b0, "R1 reset ack", per_ack, 0);
        rst_n = 1'b1;

        do_arm(20, 16'h1000, 16'h2000, 1'b1);
        check(done == 1'b0, "R1 arm clears done", done, 0);

        // R2 synchronous sampling latency
        push_xfer();
        latency(n);
        check(n == 3, "R2 sync latency", n, 3);
        drain();

        // R2 synchronized sampling latency
        cfg_sync_req = 1'b0;
        push_xfer();
        latency(n);
        check(n == 4, "R2 synchronized latency", n, 4);
        drain();
        cfg_sync_req = 1'b1;

        // R3 extra edges while pending are discarded
        base = wr_count;
        grant_en = 1'b0;
        pulse(); pulse(); pulse();
        repeat (4) @(negedge clk);
        push_xfer();
        grant_en = 1'b1;
        drain();
        check(wr_count - base == 1, "R3 one transfer for many edges", wr_count - base, 1);

        // R4 edge in the service-start clock is kept
        base = wr_count;
        grant_en = 1'b0;
        pulse();
        while (!bus_req) @(negedge clk);
        @(negedge clk) per_req_n = 1'b0;
        @(negedge clk) begin grant_en = 1'b1; per_req_n = 1'b1; end
        push_xfer(); push_xfer();
        drain();
        check(wr_count - base == 2, "R4 same-clock edge captured", wr_count - base, 2);

        // R7 grant lost between read and write
        push_xfer();
        pulse();
        while (!(cyc_active && !cyc_write)) @(negedge clk);
        grant_en = 1'b0;
        seen = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (cyc_active || !bus_req) seen = 1'b1;
        end
        check(seen == 1'b0, "R7 no cycle while grant lost", seen, 0);
        grant_en = 1'b1;
        drain();

        // R8 back-to-back transfers
        push_xfer(); push_xfer();
        @(negedge clk) per_req_n = 1'b0;
        @(negedge clk) per_req_n = 1'b1;
        while (!(bus_req && !cyc_active)) @(negedge clk);
        per_req_n = 1'b0;
        @(negedge clk) per_req_n = 1'b1;
        drain();
        check(last_gap == 1, "R8 read follows write next clock", last_gap, 1);

        // R6/R9/R10 peripheral as destination, count of two
        do_arm(2, 16'h3000, 16'h4000, 1'b0);
        push_xfer(); pulse(); drain();
        check(done == 1'b0, "R10 not done after first", done, 0);
        push_xfer(); pulse(); drain();
        check(done == 1'b1, "R10 done at zero", done, 1);
        base = wr_count;
        seen = 1'b0;
        pulse();
        repeat (8) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        check(seen == 1'b0 && wr_count == base, "R10 edges ignored when done", seen, 0);

        do_arm(0, 16'h0, 16'h0, 1'b0);
        check(done == 1'b1, "R1 zero count arm ignored", done, 1);
        do_arm(1, 16'h5000, 16'h6000, 1'b1);
        check(done == 1'b0, "R1 re-arm clears done", done, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule